// File: doc/BRIEF.md
# Two-Wire Control Register Write Slave

This block is a write-only target on a two-wire serial control bus. It oversamples the bus clock and data lines with a fast system clock and detects START and STOP conditions. After each START it compares the first byte against a fixed 7-bit device address. It then collects a control byte and a data byte, and from those two bytes it builds a register index and a 9-bit register value. The value goes into an internal register file, and every accepted byte is acknowledged by pulling the data line low through an active-low output enable.

The register value is wider than one byte, so it is split across the two bytes. The control byte holds the register index in its upper seven bits and the value's most significant bit in its lowest bit. The data byte holds the remaining eight value bits. Each write is a fixed three-byte transaction. After the third acknowledge the slave ignores the bus until the next START or STOP. On-chip logic reads the register file through a separate parallel port.

Top module: `twowire_regslave`

## Requirements
- R1: During and after reset `sda_oe_n` is 1 and every one of the 128 register entries reads 0.
- R2: An address byte whose upper seven bits are 0011010 and whose lowest bit (R/W) is 0 is acknowledged: `sda_oe_n` is 0 while the bus clock is high in the ninth bit.
- R3: An address byte with any other upper seven bits, or with R/W = 1, is not acknowledged. No later byte before the next START is acknowledged, and no register changes.
- R4: After an accepted address byte, both the control byte and the data byte are acknowledged.
- R5: A completed write stores {control[0], data[7:0]} into the entry indexed by control[7:1]. With the default configuration, `rd_data` shows the entry selected by `rd_addr` one system clock later.
- R6: A register is written only once the data byte's acknowledge bit has completed. A STOP that comes earlier leaves every register unchanged.
- R7: Bytes clocked after the third byte and before STOP are not acknowledged and change no register.
- R8: A START in the middle of a transaction discards the bytes collected so far and restarts at the address byte.
- R9: `sda_oe_n` stays 1 while the bus master drives any of the eight bits of a byte.
- R10: After a STOP, bytes clocked without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |
| rd_addr | input | 7 | Register index for the local read port |
| rd_data | output | 9 | Contents of the selected register |

## Verification
The bench checks that the ninth data bit, which travels in the control byte's lowest bit, lands at bit 8 of the stored value and does not shift the index. A design that got this wrong would store values off by one bit or write to the neighbouring register. Truncated transactions end with STOP after the control byte and in the middle of the data byte. A design that commits too early would corrupt a register on these aborted writes. A repeated START between the control and data bytes must not let the stale control byte land. Extra fourth bytes, R/W = 1, foreign addresses and unframed bytes after STOP must all stay unacknowledged; a slave that kept counting bytes or missed the STOP would acknowledge them.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      TW_IDLE = 2'd0,
      TW_BITS = 2'd1,
      TW_ACK  = 2'd2,
      TW_SKIP = 2'd3
   } tw_state_t;

   localparam int TW_BYTE_W = 8;
   localparam int TW_XFER_BYTES = 3;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ch;
   logic [STAGES-1:0] sda_ch;
   logic              scl_p;
   logic              sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
         scl_p  <= scl_ch[STAGES-1];
         sda_p  <= sda_ch[STAGES-1];
      end
   end

   assign scl_lvl   = scl_ch[STAGES-1];
   assign sda_lvl   = sda_ch[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_p;
   assign scl_fall  = ~scl_lvl & scl_p;
   assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;

   AST_BUS_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det, scl_rise, scl_fall})); // R10
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
   import tw_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b0011010,
   parameter int         AW       = 7,
   parameter int         DW       = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   output logic          ack_drive,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [DW-1:0] wdata
);
   localparam int HI_BITS = DW - TW_BYTE_W;
   localparam int CNT_W   = $clog2(TW_BYTE_W + 1);

   generate
      if (HI_BITS < 0 || AW + HI_BITS != TW_BYTE_W) begin : g_bad_split
         $error("tw_ctrl: AW plus the data bits above eight must fill one byte");
      end
   endgenerate

   tw_state_t              state;
   logic [CNT_W-1:0]       bit_cnt;
   logic [1:0]             byte_idx;
   logic [TW_BYTE_W-1:0]   shreg;
   logic [TW_BYTE_W-1:0]   ctrl_q;
   logic [TW_BYTE_W-1:0]   data_q;
   logic                   byte_done;

   assign byte_done = scl_fall && (bit_cnt == CNT_W'(TW_BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TW_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         ctrl_q   <= '0;
         data_q   <= '0;
         we       <= 1'b0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            state    <= TW_BITS;
            bit_cnt  <= '0;
            byte_idx <= '0;
         end else if (stop_det) begin
            state    <= TW_IDLE;
         end else begin
            case (state)
               TW_BITS: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[TW_BYTE_W-2:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     case (byte_idx)
                        2'd0: state <= (shreg == {DEV_ADDR, 1'b0}) ? TW_ACK : TW_SKIP;
                        2'd1: begin
                           ctrl_q <= shreg;
                           state  <= TW_ACK;
                        end
                        default: begin
                           data_q <= shreg;
                           state  <= TW_ACK;
                        end
                     endcase
                  end
               end
               TW_ACK: begin
                  if (scl_fall) begin
                     if (byte_idx == 2'(TW_XFER_BYTES - 1)) begin
                        we    <= 1'b1;
                        state <= TW_SKIP;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        bit_cnt  <= '0;
                        state    <= TW_BITS;
                     end
                  end
               end
               default: state <= state;
            endcase
         end
      end
   end

   assign ack_drive = (state == TW_ACK);
   assign waddr     = ctrl_q[TW_BYTE_W-1 -: AW];

   generate
      if (HI_BITS > 0) begin : g_split_value
         assign wdata = {ctrl_q[HI_BITS-1:0], data_q};
      end else begin : g_byte_value
         assign wdata = DW'(data_q);
      end
   endgenerate

   AST_WRITE_AFTER_THIRD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ($past(state) == TW_ACK && $past(byte_idx) == 2'd2 && $past(scl_fall))); // R6
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == TW_BITS && bit_cnt == '0 && byte_idx == 2'd0)); // R8
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == TW_IDLE && !ack_drive)); // R10
   AST_ACK_BEGINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_drive) |-> !scl_lvl); // R9
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
   parameter int AW     = 7,
   parameter int DW     = 9,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   generate
      if (DEPTH > 4096) begin : g_bad_depth
         $error("tw_regfile: AW too large for a flop register file");
      end
   endgenerate

   logic [DW-1:0] regs [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else if (we_i) begin
         regs[waddr_i] <= wdata_i;
      end
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_o <= '0;
            else        rdata_o <= regs[raddr_i];
         end
      end else begin : g_rd_comb
         assign rdata_o = regs[raddr_i];
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (regs[$past(waddr_i)] == $past(wdata_i))); // R5
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
   parameter logic [6:0] DEV_ADDR      = 7'b0011010,
   parameter int         REG_AW        = 7,
   parameter int         REG_DW        = 9,
   parameter int         SYNC_STAGES   = 2,
   parameter bit         RD_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_n,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [REG_DW-1:0] rd_data
);
   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic              ack_drive, we;
   logic [REG_AW-1:0] waddr;
   logic [REG_DW-1:0] wdata;

   tw_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tw_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW), .DW(REG_DW)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .ack_drive (ack_drive),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata)
   );

   tw_regfile #(.AW(REG_AW), .DW(REG_DW), .RD_REG(RD_REGISTERED)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   assign sda_oe_n = ~ack_drive;

   AST_RESET_RELEASED: assert property (@(posedge clk) !rst_n |-> sda_oe_n); // R1
endmodule

// File: tb/test_twowire_regslave.sv
module test_twowire_regslave;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe_n;
   logic       sda_line;
   logic [6:0] rd_addr = '0;
   logic [8:0] rd_data;
   logic [8:0] exp_regs [128];
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;
   assign sda_line = sda_m & sda_oe_n;

   twowire_regslave i_twowire_regslave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_n (sda_oe_n),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(2);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits, output bit stray);
      stray = 1'b0;
      for (int i = 7; i > 7 - nbits; i--) begin
         sda_m = b[i]; tick(H - 2);
         scl_m = 1'b1; tick(H / 2);
         if (!sda_oe_n) stray = 1'b1;
         tick(H / 2);
         scl_m = 1'b0; tick(2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked, output bit stray);
      send_bits(b, 8, stray);
      sda_m = 1'b1; tick(H - 2);
      scl_m = 1'b1; tick(H / 2);
      acked = !sda_oe_n;
      tick(H / 2);
      scl_m = 1'b0; tick(2);
   endtask

   function automatic logic [7:0] dev_byte(input bit good, input bit rw, input logic [6:0] other);
      logic [6:0] a;
      a = good ? 7'b0011010 : ((other == 7'b0011010) ? 7'b0011011 : other);
      return {a, rw};
   endfunction

   // full transaction; returns acks of the three bytes and any stray drive
   task automatic write_txn(input logic [7:0] b0, input logic [6:0] ra, input logic [8:0] val,
                            output logic [2:0] acks, output bit stray);
      bit a, s;
      stray = 1'b0;
      bus_start();
      send_byte(b0, a, s); acks[2] = a; stray |= s;
      send_byte({ra, val[8]}, a, s); acks[1] = a; stray |= s;
      send_byte(val[7:0], a, s); acks[0] = a; stray |= s;
      bus_stop();
   endtask

   task automatic read_chk(input logic [6:0] a, input string req);
      rd_addr = a; tick(2);
      chk(rd_data == exp_regs[a], req, int'(rd_data), int'(exp_regs[a]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] acks;
      bit         stray, a, s, all_zero;
      void'($urandom(32'd1234));
      for (int i = 0; i < 128; i++) exp_regs[i] = '0;

      // R1: reset state
      tick(5);
      chk(sda_oe_n == 1'b1, "R1 oe during reset", int'(sda_oe_n), 1);
      rst_n = 1'b1; tick(4);
      chk(sda_oe_n == 1'b1, "R1 oe after reset", int'(sda_oe_n), 1);
      all_zero = 1'b1;
      for (int i = 0; i < 128; i++) begin
         rd_addr = 7'(i); tick(2);
         if (rd_data != 9'd0) all_zero = 1'b0;
      end
      chk(all_zero, "R1 all entries zero", int'(all_zero), 1);

      // R2 R4 R5 R9: directed writes, D8 set and clear, boundary indices
      write_txn(dev_byte(1, 0, 0), 7'h7F, 9'h1FF, acks, stray);
      exp_regs[7'h7F] = 9'h1FF;
      chk(acks[2], "R2 address ack", int'(acks[2]), 1);
      chk(acks[1:0] == 2'b11, "R4 ctrl/data ack", int'(acks[1:0]), 3);
      chk(!stray, "R9 no drive in data bits", int'(stray), 0);
      read_chk(7'h7F, "R5 top index full value");
      write_txn(dev_byte(1, 0, 0), 7'h00, 9'h100, acks, stray);
      exp_regs[0] = 9'h100;
      read_chk(7'h00, "R5 index zero D8 only");
      read_chk(7'h01, "R5 neighbour untouched");
      write_txn(dev_byte(1, 0, 0), 7'h05, 9'h0AA, acks, stray);
      exp_regs[5] = 9'h0AA;
      read_chk(7'h05, "R5 D8 clear");

      // R3: foreign address, then R/W = 1
      write_txn(dev_byte(0, 0, 7'h50), 7'h05, 9'h155, acks, stray);
      chk(acks == 3'b000, "R3 foreign address no ack", int'(acks), 0);
      read_chk(7'h05, "R3 foreign address no write");
      write_txn(dev_byte(1, 1, 0), 7'h05, 9'h155, acks, stray);
      chk(acks == 3'b000, "R3 read bit no ack", int'(acks), 0);
      read_chk(7'h05, "R3 read bit no write");

      // R6: STOP after control byte, STOP in middle of data byte
      bus_start();
      send_byte(dev_byte(1, 0, 0), a, s);
      send_byte({7'h05, 1'b1}, a, s);
      bus_stop();
      read_chk(7'h05, "R6 stop after ctrl");
      bus_start();
      send_byte(dev_byte(1, 0, 0), a, s);
      send_byte({7'h05, 1'b1}, a, s);
      send_bits(8'h33, 4, s);
      bus_stop();
      read_chk(7'h05, "R6 stop mid data");

      // R7: fourth byte ignored
      bus_start();
      send_byte(dev_byte(1, 0, 0), a, s);
      send_byte({7'h22, 1'b0}, a, s);
      send_byte(8'h5A, a, s);
      send_byte(8'hC3, a, s);
      chk(!a, "R7 fourth byte no ack", int'(a), 0);
      bus_stop();
      exp_regs[7'h22] = 9'h05A;
      read_chk(7'h22, "R7 value from third byte");

      // R8: repeated START after control byte
      bus_start();
      send_byte(dev_byte(1, 0, 0), a, s);
      send_byte({7'h09, 1'b1}, a, s);
      bus_start();
      send_byte(dev_byte(1, 0, 0), a, s);
      chk(a, "R8 address acked after restart", int'(a), 1);
      send_byte({7'h0A, 1'b0}, a, s);
      send_byte(8'h77, a, s);
      bus_stop();
      exp_regs[7'h0A] = 9'h077;
      read_chk(7'h0A, "R8 new target written");
      read_chk(7'h09, "R8 stale target untouched");

      // R10: byte clocked after STOP without START
      scl_m = 1'b0; tick(H);
      send_byte(dev_byte(1, 0, 0), a, s);
      chk(!a, "R10 no ack without start", int'(a), 0);
      scl_m = 1'b1; tick(H);

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [6:0] ra;
         logic [8:0] val;
         bit good;
         ra   = 7'($urandom_range(0, 127));
         val  = 9'($urandom_range(0, 511));
         good = ($urandom_range(0, 4) != 0);
         write_txn(dev_byte(good, 0, 7'($urandom_range(0, 127))), ra, val, acks, stray);
         if (good) exp_regs[ra] = val;
         chk(acks == (good ? 3'b111 : 3'b000), good ? "R4 random acks" : "R3 random acks",
             int'(acks), good ? 7 : 0);
         chk(!stray, "R9 random no stray drive", int'(stray), 0);
      end
      for (int i = 0; i < 128; i++) read_chk(7'(i), "R5 final readback");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule